// File: doc/BRIEF.md
# CPU Debug Control Port

This block is a small bus slave that gives an external debugger control over a soft processor core. A debugger writes one command word to halt the core, release it, request a single instruction step, pulse a core reset, and choose which of 64 core or peripheral registers to inspect. It then reads the chosen register through a second, data-window address once the core reports that it has come to a stop.

The slave side is a pipelined request/acknowledge bus with one address bit. It never stalls, and every accepted strobe is acknowledged on the following clock, with read data valid in that acknowledge cycle. On the core side the block drives a level halt request, one-clock step and reset pulses, and a 6-bit register index. It takes back the indexed register's value, a stopped status and a pending-interrupt flag. The window value is captured on every clock in which the core reports it has stopped, and is held while the core runs. A read of the window while the core is running therefore returns the last value captured rather than blocking the bus.

Register index map (decoded by the core, carried unchanged here): 0 to 15 supervisor set (general registers 0 to 12, stack pointer 13, flags 14, program counter 15), 16 to 31 the user set in the same order, 32 to 39 eight peripheral registers, 44 to 47 four user performance counters.

Top module: `dbg_ctrl_port`

## Requirements
- R1: After reset, halt request is 1, step and reset requests are 0, the register index is 0, and ack and stall are 0.
- R2: A strobe with cycle high is accepted in that clock (stall is always 0) and is acknowledged by exactly one ack in the next clock; ack is never given without a strobe one clock earlier.
- R3: A write to address 0 sets the index from bits 5:0 of the write data in the next clock, and sets halt request to the OR of bit 10 (halt) and bit 8 (step).
- R4: A write to address 0 with bit 8 set gives a step request exactly one clock wide, in the clock after the write, with halt request held at 1.
- R5: A write to address 0 with bit 6 set gives a reset request exactly one clock wide in the clock after the write; when bit 10 is also set, halt request stays 1 afterwards.
- R6: A read of address 0 returns halt request at bit 10, the live stopped status at bit 9, the pending-interrupt flag at bit 7, and the index at bits 5:0; bits 8, 6 and 31:11 read 0.
- R7: A read of address 1 returns the register value captured in the last clock in which the stopped status was 1; while the status is 0 the captured value does not change.
- R8: A write to address 1, and a strobe with cycle low, change neither halt request nor the index; a strobe with cycle low gets no ack.
- R9: A write of 0 to address 0 drops halt request, releasing the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Request strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 1 | 0 command/status word, 1 data window |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Acknowledge, one clock after the strobe |
| bus_stall | output | 1 | Request stall, always 0 |
| bus_rdata | output | 32 | Read data, valid with ack |
| cpu_halt_req | output | 1 | Level halt request to the core |
| cpu_step_req | output | 1 | One-clock single-step request |
| cpu_reset_req | output | 1 | One-clock core reset request |
| cpu_reg_sel | output | 6 | Index of the register to inspect |
| cpu_reg_val | input | 32 | Value of the indexed register |
| cpu_stalled | input | 1 | Core has stopped |
| cpu_irq_pending | input | 1 | Interrupt pending in the core |

## Verification
The step and reset pulses are two functions that can fall in the same clock, because both come from one command write. The bench writes a word with halt, step and reset bits together and judges, one clock after the write, that both pulses are high, that both drop together on the next clock, that each pulse counter moved by exactly one, and that halt request is still 1. A second overlap is a window read while the core is running after its register values have changed; the bench expects the value captured before the release, then re-halts and expects the new value.

// File: rtl/dbg_ctrl_pkg.sv
package dbg_ctrl_pkg;

    // Command/status word bit positions: the core-side decoder and the
    // debugger software both rely on these.
    localparam int unsigned CMD_HALT_BIT  = 10;
    localparam int unsigned CMD_STALL_BIT = 9;
    localparam int unsigned CMD_STEP_BIT  = 8;
    localparam int unsigned CMD_IRQ_BIT   = 7;
    localparam int unsigned CMD_RESET_BIT = 6;

    typedef enum logic {
        ADDR_CMD = 1'b0,
        ADDR_WIN = 1'b1
    } dbg_addr_e;

endpackage

// File: rtl/dbg_cmd_reg.sv
module dbg_cmd_reg
    import dbg_ctrl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              halt_o,
    output logic              step_o,
    output logic              reset_o,
    output logic [SEL_W-1:0]  sel_o
);

    typedef struct packed {
        logic             halt;
        logic             step;
        logic             rst;
        logic [SEL_W-1:0] sel;
    } cmd_state_t;

    cmd_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.step = 1'b0;
        st_d.rst  = 1'b0;
        if (wr_en_i) begin
            // a step request always re-halts so the core stops after it
            st_d.halt = wdata_i[CMD_HALT_BIT] | wdata_i[CMD_STEP_BIT];
            st_d.step = wdata_i[CMD_STEP_BIT];
            st_d.rst  = wdata_i[CMD_RESET_BIT];
            st_d.sel  = wdata_i[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.halt <= 1'b1;
            st_q.step <= 1'b0;
            st_q.rst  <= 1'b0;
            st_q.sel  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign halt_o  = st_q.halt;
    assign step_o  = st_q.step;
    assign reset_o = st_q.rst;
    assign sel_o   = st_q.sel;

    AST_STEP_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> $past(wr_en_i && wdata_i[CMD_STEP_BIT])); // R4
    AST_STEP_KEEPS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> halt_o); // R4
    AST_RESET_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_o |-> $past(wr_en_i && wdata_i[CMD_RESET_BIT])); // R5
    AST_CMD_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(halt_o) && $stable(sel_o))); // R8

endmodule

// File: rtl/dbg_data_win.sv
module dbg_data_win #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stalled_i,
    input  logic [DATA_W-1:0] val_i,
    output logic [DATA_W-1:0] win_o
);

    typedef struct packed {
        logic [DATA_W-1:0] win;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stalled_i) begin
            st_d.win = val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.win <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_o = st_q.win;

    AST_WIN_HOLD_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        !stalled_i |=> $stable(win_o)); // R7
    AST_WIN_CAPTURE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        stalled_i |=> (win_o == $past(val_i))); // R7

endmodule

// File: rtl/dbg_bus_resp.sv
module dbg_bus_resp
    import dbg_ctrl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] win_i,
    output logic              ack_o,
    output logic              stall_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              cmd_wr_o
);

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } resp_state_t;

    resp_state_t st_d, st_q;
    logic        accept;

    assign stall_o  = 1'b0;
    assign accept   = cyc_i & stb_i & ~stall_o;
    assign cmd_wr_o = accept & we_i & (addr_i == ADDR_CMD);

    always_comb begin
        st_d     = st_q;
        st_d.ack = accept;
        if (accept && !we_i) begin
            st_d.rdata = (addr_i == ADDR_WIN) ? win_i : status_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ack   <= 1'b0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o   = st_q.ack;
    assign rdata_o = st_q.rdata;

    AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i && stb_i) |=> ack_o); // R2
    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(cyc_i && stb_i)); // R2
    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i && stb_i && !we_i && addr_i == ADDR_CMD) |=> (rdata_o == $past(status_i))); // R6

endmodule

// File: rtl/dbg_ctrl_port.sv
module dbg_ctrl_port
    import dbg_ctrl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic              bus_stall,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_halt_req,
    output logic              cpu_step_req,
    output logic              cpu_reset_req,
    output logic [SEL_W-1:0]  cpu_reg_sel,
    input  logic [DATA_W-1:0] cpu_reg_val,
    input  logic              cpu_stalled,
    input  logic              cpu_irq_pending
);

    logic              cmd_wr;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] win_val;

    dbg_cmd_reg #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (cmd_wr),
        .wdata_i (bus_wdata),
        .halt_o  (cpu_halt_req),
        .step_o  (cpu_step_req),
        .reset_o (cpu_reset_req),
        .sel_o   (cpu_reg_sel)
    );

    dbg_data_win #(
        .DATA_W (DATA_W)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .stalled_i (cpu_stalled),
        .val_i     (cpu_reg_val),
        .win_o     (win_val)
    );

    // step and reset read back as 0; the stopped status is live
    always_comb begin
        status_word                   = '0;
        status_word[SEL_W-1:0]        = cpu_reg_sel;
        status_word[CMD_IRQ_BIT]      = cpu_irq_pending;
        status_word[CMD_STALL_BIT]    = cpu_stalled;
        status_word[CMD_HALT_BIT]     = cpu_halt_req;
    end

    dbg_bus_resp #(
        .DATA_W (DATA_W)
    ) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_i    (bus_cyc),
        .stb_i    (bus_stb),
        .we_i     (bus_we),
        .addr_i   (bus_addr),
        .status_i (status_word),
        .win_i    (win_val),
        .ack_o    (bus_ack),
        .stall_o  (bus_stall),
        .rdata_o  (bus_rdata),
        .cmd_wr_o (cmd_wr)
    );

    AST_STALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_stb) |-> !bus_stall); // R2
    AST_WIN_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_stb && bus_we && bus_addr == ADDR_WIN) |=> ($stable(cpu_halt_req) && $stable(cpu_reg_sel))); // R8

endmodule

// File: tb/dbg_ctrl_port_bench.sv
module dbg_ctrl_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, bus_stall;
    logic [31:0] bus_rdata;
    logic        cpu_halt_req, cpu_step_req, cpu_reset_req;
    logic [5:0]  cpu_reg_sel;
    logic [31:0] cpu_reg_val;
    logic        cpu_stalled;
    logic        cpu_irq_pending = 1'b0;

    int checks = 0;
    int failures = 0;
    int step_cnt = 0;
    int rst_cnt = 0;
    logic [3:0] salt = 4'h1;

    always #2.5 clk = ~clk;

    dbg_ctrl_port u_dbg_ctrl_port (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_cyc         (bus_cyc),
        .bus_stb         (bus_stb),
        .bus_we          (bus_we),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_ack         (bus_ack),
        .bus_stall       (bus_stall),
        .bus_rdata       (bus_rdata),
        .cpu_halt_req    (cpu_halt_req),
        .cpu_step_req    (cpu_step_req),
        .cpu_reset_req   (cpu_reset_req),
        .cpu_reg_sel     (cpu_reg_sel),
        .cpu_reg_val     (cpu_reg_val),
        .cpu_stalled     (cpu_stalled),
        .cpu_irq_pending (cpu_irq_pending)
    );

    // Core model: stops one clock after halt request, runs 3 clocks per step.
    function automatic logic [31:0] regval(input logic [5:0] i, input logic [3:0] s);
        return {s, 6'h15, i, 10'h2C3, i ^ 6'h2A};
    endfunction

    logic       halt_seen;
    logic [1:0] run_left;
    assign cpu_reg_val = regval(cpu_reg_sel, salt);
    assign cpu_stalled = halt_seen && (run_left == 2'd0);

    always @(posedge clk) begin
        if (!rst_n) begin
            halt_seen <= 1'b0;
            run_left  <= 2'd0;
        end else begin
            halt_seen <= cpu_halt_req;
            if (cpu_step_req) run_left <= 2'd3;
            else if (run_left != 2'd0) run_left <= run_left - 2'd1;
        end
        if (cpu_step_req) step_cnt++;
        if (cpu_reset_req) rst_cnt++;
    end

    function automatic logic [31:0] exp_status(input logic h, input logic s,
                                               input logic q, input logic [5:0] sel);
        logic [31:0] w;
        w = '0;
        w[10] = h; w[9] = s; w[7] = q; w[5:0] = sel;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at posedge+1; returns at posedge+1 one clock after the ack.
    task automatic bus_op(input logic we, input logic a, input logic [31:0] wd,
                          output logic [31:0] rd);
        bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        @(posedge clk); #1;
        bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
        chk("R2 ack one clock after strobe", {31'b0, bus_ack}, 32'd1);
        rd = bus_rdata;
        @(posedge clk); #1;
        chk("R2 single ack", {31'b0, bus_ack}, 32'd0);
    endtask

    task automatic wr_cmd(input logic [31:0] wd);
        logic [31:0] dummy;
        bus_op(1'b1, 1'b0, wd, dummy);
    endtask

    task automatic poll_stopped(output logic [31:0] st);
        logic [31:0] r;
        r = '0;
        for (int n = 0; n < 20; n++) begin
            bus_op(1'b0, 1'b0, 32'd0, r);
            if (r[9]) break;
        end
        st = r;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r, st;
        int sc, rc;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 halt", {31'b0, cpu_halt_req}, 32'd1);
        chk("R1 step", {31'b0, cpu_step_req}, 32'd0);
        chk("R1 reset", {31'b0, cpu_reset_req}, 32'd0);
        chk("R1 sel", {26'b0, cpu_reg_sel}, 32'd0);
        chk("R1 ack/stall", {30'b0, bus_ack, bus_stall}, 32'd0);
        @(posedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 halt after release", {31'b0, cpu_halt_req}, 32'd1);

        // R3 R6 R7 sweep over every index while halted
        for (int i = 0; i < 64; i++) begin
            wr_cmd(32'h400 | 32'(i));
            poll_stopped(st);
            chk("R6 status after halt+index", st, exp_status(1'b1, 1'b1, 1'b0, 6'(i)));
            bus_op(1'b0, 1'b1, 32'd0, r);
            chk("R7 window value", r, regval(6'(i), salt));
        end

        // R6 interrupt flag
        cpu_irq_pending = 1'b1;
        bus_op(1'b0, 1'b0, 32'd0, r);
        chk("R6 irq bit", r, exp_status(1'b1, 1'b1, 1'b1, 6'd63));
        cpu_irq_pending = 1'b0;

        // R9 release, R7 window held while running
        wr_cmd(32'h0000_0000 | 32'd14);
        chk("R9 halt dropped", {31'b0, cpu_halt_req}, 32'd0);
        salt = 4'h9;
        bus_op(1'b0, 1'b0, 32'd0, r);
        chk("R9 status running", r, exp_status(1'b0, 1'b0, 1'b0, 6'd14));
        bus_op(1'b0, 1'b1, 32'd0, r);
        chk("R7 window held while running", r, regval(6'd14, 4'h1));
        wr_cmd(32'h400 | 32'd14);
        poll_stopped(st);
        bus_op(1'b0, 1'b1, 32'd0, r);
        chk("R7 window recaptured", r, regval(6'd14, 4'h9));

        // R4 step alone keeps halt, one-clock pulse
        sc = step_cnt;
        bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 32'h100 | 32'd5;
        @(posedge clk); #1;
        bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
        chk("R4 step pulse high", {31'b0, cpu_step_req}, 32'd1);
        chk("R3 R4 halt held by step", {31'b0, cpu_halt_req}, 32'd1);
        chk("R3 sel from step write", {26'b0, cpu_reg_sel}, 32'd5);
        @(posedge clk); #1;
        chk("R4 step pulse width", {31'b0, cpu_step_req}, 32'd0);
        poll_stopped(st);
        chk("R4 one step counted", 32'(step_cnt - sc), 32'd1);
        bus_op(1'b0, 1'b1, 32'd0, r);
        chk("R7 window after step", r, regval(6'd5, 4'h9));

        // R5 reset with halt
        rc = rst_cnt;
        bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 32'h440 | 32'd7;
        @(posedge clk); #1;
        bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
        chk("R5 reset pulse high", {31'b0, cpu_reset_req}, 32'd1);
        @(posedge clk); #1;
        chk("R5 reset pulse width", {31'b0, cpu_reset_req}, 32'd0);
        chk("R5 halt kept", {31'b0, cpu_halt_req}, 32'd1);
        chk("R5 one reset counted", 32'(rst_cnt - rc), 32'd1);

        // R4 R5 step and reset in the same write
        sc = step_cnt; rc = rst_cnt;
        bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 32'h540 | 32'd9;
        @(posedge clk); #1;
        bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
        chk("R4 R5 both pulses", {30'b0, cpu_step_req, cpu_reset_req}, 32'd3);
        @(posedge clk); #1;
        chk("R4 R5 both dropped", {30'b0, cpu_step_req, cpu_reset_req}, 32'd0);
        chk("R4 R5 counts", 32'((step_cnt - sc) * 16 + (rst_cnt - rc)), 32'h11);
        chk("R4 R5 halt kept", {31'b0, cpu_halt_req}, 32'd1);
        poll_stopped(st);
        chk("R6 status after combined write", st, exp_status(1'b1, 1'b1, 1'b0, 6'd9));

        // R5 reset without halt releases
        wr_cmd(32'h040 | 32'd9);
        chk("R5 reset alone leaves halt 0", {31'b0, cpu_halt_req}, 32'd0);
        wr_cmd(32'h400 | 32'd9);
        poll_stopped(st);

        // R8 strobe without cycle: no ack, no state change
        bus_cyc = 1'b0; bus_stb = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 32'd0;
        @(posedge clk); #1;
        bus_stb = 1'b0; bus_we = 1'b0;
        chk("R8 no ack without cycle", {31'b0, bus_ack}, 32'd0);
        @(posedge clk); #1;
        chk("R8 no ack without cycle later", {31'b0, bus_ack}, 32'd0);
        bus_op(1'b0, 1'b0, 32'd0, r);
        chk("R8 state after stray strobe", r, exp_status(1'b1, 1'b1, 1'b0, 6'd9));

        // R8 write to window address ignored
        bus_op(1'b1, 1'b1, 32'h0000_0021, r);
        bus_op(1'b0, 1'b0, 32'd0, r);
        chk("R8 window write ignored", r, exp_status(1'b1, 1'b1, 1'b0, 6'd9));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule